// File: doc/BRIEF.md
# Programmable Bit Error Rate Tester

This block is a bit error rate tester for a serial bit stream. The transmit side produces one pattern bit each time its bit enable is high. The pattern is one of three pseudorandom sequences or a repeating word of programmable length. Errors can be flipped into the outgoing stream, either one at a time on request or automatically at a decade rate.

The receive side takes one bit each time its own enable is high. It predicts each next bit from the bits it has already seen and locks to the incoming pattern. Once locked, it counts received bits and mismatches. When the line degrades, it drops out of lock and hunts again from the incoming data.

The host drives plain control inputs. These are a pattern selector, a repeat-length code and repeat word, separate transmit and receive inversion, a generator restart, resync, a counter snapshot and an error-rate code. Each counter snapshot copies the running counts into holding outputs.

Top module: `bert_engine`

## Requirements
- R1: With `pat_sel` = 0, 1 or 2, the generator emits the sequence b[n] = b[n-7]^b[n-6], b[n-11]^b[n-9] or b[n-15]^b[n-14] respectively. A `gen_load` pulse treats every earlier bit as 1, so the first bit after it is 0. Codes 4 to 7 behave as code 0.
- R2: With `pat_sel` = 3, a `gen_load` pulse loads `rep_word`. The pattern length is L = `rep_len` + 17, so code 0 gives 17 bits and code 15 gives 32 bits. Output bit n is `rep_word`[L-1-(n mod L)].
- R3: `tx_bit` changes only in cycles with `tx_en` high; it is registered, visible the cycle after the enabled edge, and inverted when `tx_inv` is 1.
- R4: A one-cycle `err_single` pulse, given with `tx_en` low, inverts exactly the next enabled output bit and no other.
- R5: With `err_rate` = k (1 to 7), every 10^k-th enabled bit after `gen_load` is inverted, that is, bit numbers 10^k-1, 2*10^k-1 and so on. Code 0 inserts no errors.
- R6: The receiver XORs each received bit with `rx_inv` and compares it with its prediction. It raises `in_sync` after 32 consecutive matching bits.
- R7: While in sync, the receiver checks blocks of 64 enabled bits that start at lock. The sixth mismatch within one block drops `in_sync` and sets the sticky `loss_flag`. The receiver then reseeds from incoming data and can lock again. `loss_clr` clears the flag.
- R8: Received bits and mismatches are counted only while `in_sync` is high; out of sync nothing is counted.
- R9: A `load_cnt` pulse copies the running bit count and error count to `bit_hold` and `err_hold`. It clears the running counts in the same cycle. Both holding outputs read 0 after reset.
- R10: When the error counter wraps from all ones, `err_ovf` is set. It stays set until the next `load_cnt`, which clears it.
- R11: A `resync` pulse forces the receiver out of sync at the next edge. The receiver then hunts for the pattern again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit bit enable |
| tx_bit | output | 1 | Transmitted pattern bit |
| rx_en | input | 1 | Receive bit enable |
| rx_bit | input | 1 | Received bit |
| pat_sel | input | 3 | Pattern selector (0/1/2 pseudorandom, 3 repeating) |
| rep_len | input | 4 | Repeat length code, L = code + 17 |
| rep_word | input | 32 | Repeating pattern word |
| tx_inv | input | 1 | Invert transmitted stream |
| rx_inv | input | 1 | Invert expected received stream |
| gen_load | input | 1 | Restart generator and auto-error counter |
| err_rate | input | 3 | Automatic error rate code |
| err_single | input | 1 | Insert one error |
| resync | input | 1 | Force receiver to reacquire |
| load_cnt | input | 1 | Snapshot and clear counters |
| loss_clr | input | 1 | Clear latched loss-of-sync flag |
| in_sync | output | 1 | Receiver locked |
| loss_flag | output | 1 | Latched loss of sync |
| bit_hold | output | BIT_CNT_W | Held bit count |
| err_hold | output | ERR_CNT_W | Held error count |
| err_ovf | output | 1 | Sticky error counter overflow |

## Verification
The assertions assume that every host control (`gen_load`, `err_single`, `resync`, `load_cnt`, `loss_clr`) is a single-cycle pulse. They also assume that the configuration inputs stay steady while a run of enabled bits is in progress. The stimulus always raises these pulses at a falling edge, with both bit enables low, and drops them one cycle later. It changes the pattern, length, inversion and rate settings only between runs, and each change is followed by a generator restart. The receive input is the transmit output looped back, with single-bit line flips added. This keeps the pattern the receiver sees fully predictable.

// File: rtl/bert_pkg.sv
package bert_pkg;

  localparam int HIST_W = 32;
  localparam int RATE_W = 24;

  localparam logic [2:0] PAT_P7  = 3'd0;
  localparam logic [2:0] PAT_P11 = 3'd1;
  localparam logic [2:0] PAT_P15 = 3'd2;
  localparam logic [2:0] PAT_REP = 3'd3;

  typedef enum logic {ST_HUNT, ST_LOCK} rx_state_t;

  // Next pattern bit from a history of earlier bits (h[0] newest).
  function automatic logic next_bit(input logic [HIST_W-1:0] h,
                                    input logic [2:0] sel,
                                    input logic [3:0] len_code);
    case (sel)
      PAT_P11: return h[10] ^ h[8];
      PAT_P15: return h[14] ^ h[13];
      PAT_REP: return h[{1'b1, len_code}];   // h[L-1], L = code + 17
      default: return h[6] ^ h[5];
    endcase
  endfunction

  // 10^r as the period of automatic error insertion.
  function automatic logic [RATE_W-1:0] decade(input logic [2:0] r);
    logic [RATE_W-1:0] v;
    v = RATE_W'(1);
    for (int i = 0; i < 7; i++) begin
      if (i < int'(r)) v = RATE_W'(v * RATE_W'(10));
    end
    return v;
  endfunction

endpackage

// File: rtl/bert_err_insert.sv
module bert_err_insert
  import bert_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       restart,
  input  logic [2:0] rate,
  input  logic       single_req,
  output logic       flip
);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              at_end;

  always_comb begin
    at_end = (rate != 3'd0) && (cnt_q >= decade(rate) - RATE_W'(1));
    flip   = pend_q | at_end;
    cnt_d  = cnt_q;
    pend_d = pend_q | single_req;
    if (restart) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d  = (at_end || rate == 3'd0) ? '0 : cnt_q + RATE_W'(1);
      pend_d = single_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/bert_pattern_gen.sv
module bert_pattern_gen
  import bert_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [2:0]        pat_sel,
  input  logic [3:0]        len_code,
  input  logic [HIST_W-1:0] rep_word,
  input  logic              invert,
  input  logic              flip,
  output logic              tx_bit
);

  logic [HIST_W-1:0] hist_q, hist_d;
  logic              bit_q, bit_d;
  logic              nb;

  always_comb begin
    nb     = next_bit(hist_q, pat_sel, len_code);
    hist_d = hist_q;
    bit_d  = bit_q;
    if (load) begin
      hist_d = (pat_sel == PAT_REP) ? rep_word : '1;
    end else if (step) begin
      hist_d = {hist_q[HIST_W-2:0], nb};
      bit_d  = nb ^ invert ^ flip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      bit_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      bit_q  <= bit_d;
    end
  end

  assign tx_bit = bit_q;

endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker
  import bert_pkg::*;
#(
  parameter int SYNC_N = 32,
  parameter int LOSS_N = 6,
  parameter int WIN_N  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       rx_bit,
  input  logic       invert,
  input  logic [2:0] pat_sel,
  input  logic [3:0] len_code,
  input  logic       resync,
  input  logic       loss_clr,
  output logic       in_sync,
  output logic       loss_flag,
  output logic       cnt_bit,
  output logic       cnt_err
);

  localparam int MW = $clog2(SYNC_N + 1);
  localparam int WW = $clog2(WIN_N);
  localparam int EW = $clog2(LOSS_N + 1);

  rx_state_t         st_q, st_d;
  logic [HIST_W-1:0] h_q, h_d;
  logic [MW-1:0]     m_q, m_d;
  logic [WW-1:0]     w_q, w_d;
  logic [EW-1:0]     e_q, e_d;
  logic              lf_q, lf_d;
  logic              data, pred, mism, lose, blk_end;

  always_comb begin
    data    = rx_bit ^ invert;
    pred    = next_bit(h_q, pat_sel, len_code);
    mism    = data != pred;
    blk_end = w_q == WW'(WIN_N - 1);
    st_d = st_q;  h_d = h_q;  m_d = m_q;  w_d = w_q;  e_d = e_q;
    lose = 1'b0;
    if (resync) begin
      st_d = ST_HUNT;
      m_d  = '0;
    end else if (step) begin
      if (st_q == ST_HUNT) begin
        h_d = {h_q[HIST_W-2:0], data};
        if (mism) begin
          m_d = '0;
        end else if (m_q == MW'(SYNC_N - 1)) begin
          st_d = ST_LOCK;
          m_d  = '0;
          w_d  = '0;
          e_d  = '0;
        end else begin
          m_d = m_q + MW'(1);
        end
      end else begin
        h_d = {h_q[HIST_W-2:0], pred};
        w_d = blk_end ? '0 : w_q + WW'(1);
        if (blk_end) e_d = '0;
        if (mism) begin
          if (e_q == EW'(LOSS_N - 1)) begin
            lose = 1'b1;
            st_d = ST_HUNT;
            m_d  = '0;
          end else if (!blk_end) begin
            e_d = e_q + EW'(1);
          end
        end
      end
    end
    lf_d = lose | (lf_q & ~loss_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT;
      h_q  <= '0;
      m_q  <= '0;
      w_q  <= '0;
      e_q  <= '0;
      lf_q <= 1'b0;
    end else begin
      st_q <= st_d;
      h_q  <= h_d;
      m_q  <= m_d;
      w_q  <= w_d;
      e_q  <= e_d;
      lf_q <= lf_d;
    end
  end

  assign in_sync   = st_q == ST_LOCK;
  assign loss_flag = lf_q;
  assign cnt_bit   = step & in_sync & ~resync;
  assign cnt_err   = cnt_bit & mism;

endmodule

// File: rtl/bert_counters.sv
module bert_counters #(
  parameter int BIT_W = 32,
  parameter int ERR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_bit,
  input  logic             inc_err,
  input  logic             load,
  output logic [BIT_W-1:0] bit_hold,
  output logic [ERR_W-1:0] err_hold,
  output logic             err_ovf
);

  logic [BIT_W-1:0] bits_q, bits_d, bh_q, bh_d;
  logic [ERR_W-1:0] errs_q, errs_d, eh_q, eh_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    bits_d = bits_q;  errs_d = errs_q;  bh_d = bh_q;  eh_d = eh_q;  ovf_d = ovf_q;
    if (load) begin
      bh_d   = bits_q;
      eh_d   = errs_q;
      bits_d = '0;
      errs_d = '0;
      ovf_d  = 1'b0;
    end else begin
      if (inc_bit) bits_d = bits_q + BIT_W'(1);
      if (inc_err) begin
        errs_d = errs_q + ERR_W'(1);
        if (&errs_q) ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      errs_q <= '0;
      bh_q   <= '0;
      eh_q   <= '0;
      ovf_q  <= 1'b0;
    end else begin
      bits_q <= bits_d;
      errs_q <= errs_d;
      bh_q   <= bh_d;
      eh_q   <= eh_d;
      ovf_q  <= ovf_d;
    end
  end

  assign bit_hold = bh_q;
  assign err_hold = eh_q;
  assign err_ovf  = ovf_q;

endmodule

// File: rtl/bert_engine.sv
module bert_engine #(
  parameter int SYNC_LEN  = 32,
  parameter int LOSS_ERRS = 6,
  parameter int LOSS_WIN  = 64,
  parameter int BIT_CNT_W = 32,
  parameter int ERR_CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  output logic                 tx_bit,
  input  logic                 rx_en,
  input  logic                 rx_bit,
  input  logic [2:0]           pat_sel,
  input  logic [3:0]           rep_len,
  input  logic [31:0]          rep_word,
  input  logic                 tx_inv,
  input  logic                 rx_inv,
  input  logic                 gen_load,
  input  logic [2:0]           err_rate,
  input  logic                 err_single,
  input  logic                 resync,
  input  logic                 load_cnt,
  input  logic                 loss_clr,
  output logic                 in_sync,
  output logic                 loss_flag,
  output logic [BIT_CNT_W-1:0] bit_hold,
  output logic [ERR_CNT_W-1:0] err_hold,
  output logic                 err_ovf
);

  logic flip, cnt_bit, cnt_err;

  bert_err_insert u_ins (
    .clk(clk), .rst_n(rst_n), .step(tx_en), .restart(gen_load),
    .rate(err_rate), .single_req(err_single), .flip(flip)
  );

  bert_pattern_gen u_gen (
    .clk(clk), .rst_n(rst_n), .step(tx_en), .load(gen_load),
    .pat_sel(pat_sel), .len_code(rep_len), .rep_word(rep_word),
    .invert(tx_inv), .flip(flip), .tx_bit(tx_bit)
  );

  bert_rx_checker #(.SYNC_N(SYNC_LEN), .LOSS_N(LOSS_ERRS), .WIN_N(LOSS_WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(rx_en), .rx_bit(rx_bit), .invert(rx_inv),
    .pat_sel(pat_sel), .len_code(rep_len), .resync(resync), .loss_clr(loss_clr),
    .in_sync(in_sync), .loss_flag(loss_flag), .cnt_bit(cnt_bit), .cnt_err(cnt_err)
  );

  bert_counters #(.BIT_W(BIT_CNT_W), .ERR_W(ERR_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_bit(cnt_bit), .inc_err(cnt_err), .load(load_cnt),
    .bit_hold(bit_hold), .err_hold(err_hold), .err_ovf(err_ovf)
  );

endmodule

// File: rtl/bert_engine_sva.sv
module bert_engine_sva #(
  parameter int BIT_W = 32,
  parameter int ERR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_bit,
  input logic             rx_en,
  input logic             resync,
  input logic             load_cnt,
  input logic             loss_clr,
  input logic             in_sync,
  input logic             loss_flag,
  input logic [BIT_W-1:0] bit_hold,
  input logic [ERR_W-1:0] err_hold,
  input logic             err_ovf
);

  assert_tx_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> $stable(tx_bit));

  assert_resync_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !in_sync);

  assert_sync_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync && !rx_en && !resync |=> in_sync);

  assert_loss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loss_flag && !loss_clr |=> loss_flag);

  assert_loss_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loss_flag) |-> $fell(in_sync));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf && !load_cnt |=> err_ovf);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cnt |=> $stable(bit_hold) && $stable(err_hold));

  assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_cnt |=> !err_ovf);

endmodule

bind bert_engine bert_engine_sva #(.BIT_W(BIT_CNT_W), .ERR_W(ERR_CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit), .rx_en(rx_en),
  .resync(resync), .load_cnt(load_cnt), .loss_clr(loss_clr), .in_sync(in_sync),
  .loss_flag(loss_flag), .bit_hold(bit_hold), .err_hold(err_hold), .err_ovf(err_ovf)
);

// File: tb/bert_engine_tb.sv
module bert_engine_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, tx_en, rx_en, line_flip;
  logic [2:0]  pat_sel, err_rate;
  logic [3:0]  rep_len;
  logic [31:0] rep_word;
  logic        tx_inv, rx_inv, gen_load, err_single, resync, load_cnt, loss_clr;
  logic        tx_bit, in_sync, loss_flag, err_ovf;
  logic [31:0] bit_hold;
  logic [23:0] err_hold;
  logic        n_tx_bit, n_in_sync, n_loss_flag, n_err_ovf;
  logic [31:0] n_bit_hold;
  logic [3:0]  n_err_hold;

  wire rx_line   = tx_bit ^ line_flip;
  wire n_rx_line = n_tx_bit ^ line_flip;

  bert_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit), .rx_en(rx_en),
    .rx_bit(rx_line), .pat_sel(pat_sel), .rep_len(rep_len), .rep_word(rep_word),
    .tx_inv(tx_inv), .rx_inv(rx_inv), .gen_load(gen_load), .err_rate(err_rate),
    .err_single(err_single), .resync(resync), .load_cnt(load_cnt), .loss_clr(loss_clr),
    .in_sync(in_sync), .loss_flag(loss_flag), .bit_hold(bit_hold),
    .err_hold(err_hold), .err_ovf(err_ovf)
  );

  bert_engine #(.ERR_CNT_W(4)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(n_tx_bit), .rx_en(rx_en),
    .rx_bit(n_rx_line), .pat_sel(pat_sel), .rep_len(rep_len), .rep_word(rep_word),
    .tx_inv(tx_inv), .rx_inv(rx_inv), .gen_load(gen_load), .err_rate(err_rate),
    .err_single(err_single), .resync(resync), .load_cnt(load_cnt), .loss_clr(loss_clr),
    .in_sync(n_in_sync), .loss_flag(n_loss_flag), .bit_hold(n_bit_hold),
    .err_hold(n_err_hold), .err_ovf(n_err_ovf)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard: the driver pushes expected transmit bits, the monitor pops them.
  logic  sb_q[$];
  string sb_req = "R1";
  logic  mon_seen;
  always @(posedge clk) mon_seen <= tx_en;
  always @(negedge clk) begin
    if (rst_n && mon_seen && sb_q.size() > 0) chk(sb_req, tx_bit, sb_q.pop_front());
  end

  logic [31:0] mh;
  int          midx;
  logic        sp;

  function automatic int pow10(input int k);
    int v = 1;
    for (int i = 0; i < k; i++) v = v * 10;
    return v;
  endfunction

  task automatic next_exp(output logic b);
    int len;
    len = int'(rep_len) + 17;
    if (pat_sel == 3'd3) begin
      b = rep_word[len - 1 - (midx % len)];
    end else begin
      case (pat_sel)
        3'd1:    b = mh[10] ^ mh[8];
        3'd2:    b = mh[14] ^ mh[13];
        default: b = mh[6] ^ mh[5];
      endcase
      mh = {mh[30:0], b};
    end
    if (err_rate != 3'd0 && ((midx + 1) % pow10(int'(err_rate))) == 0) b = ~b;
  endtask

  task automatic drive_bit(input logic lf);
    logic b;
    next_exp(b);
    b  = b ^ tx_inv ^ sp;
    sp = 1'b0;
    midx++;
    sb_q.push_back(b);
    tx_en = 1'b1; rx_en = 1'b1; line_flip = lf;
    @(negedge clk);
    tx_en = 1'b0; rx_en = 1'b0; line_flip = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b0);
  endtask

  task automatic do_gen_load();
    gen_load = 1'b1; @(negedge clk); gen_load = 1'b0;
    mh = '1; midx = 0;
  endtask

  task automatic do_load_cnt();
    load_cnt = 1'b1; @(negedge clk); load_cnt = 1'b0;
  endtask

  task automatic do_loss_clr();
    loss_clr = 1'b1; @(negedge clk); loss_clr = 1'b0;
  endtask

  task automatic do_resync();
    resync = 1'b1; @(negedge clk); resync = 1'b0;
  endtask

  task automatic do_single();
    err_single = 1'b1; @(negedge clk); err_single = 1'b0;
    sp = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 0; rx_en = 0; line_flip = 0;
    pat_sel = 3'd0; err_rate = 3'd0; rep_len = 4'd0; rep_word = '0;
    tx_inv = 0; rx_inv = 0; gen_load = 0; err_single = 0; resync = 0;
    load_cnt = 0; loss_clr = 0; mh = '1; midx = 0; sp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset bit_hold", bit_hold, 0);
    chk("R9 reset err_hold", err_hold, 0);
    chk("R10 reset err_ovf", err_ovf, 0);
    chk("R6 reset in_sync", in_sync, 0);
    chk("R7 reset loss_flag", loss_flag, 0);
    chk("R3 reset tx_bit", tx_bit, 0);

    // R1 pseudorandom patterns, with lock on the loopback (R6)
    sb_req = "R1"; pat_sel = 3'd0; do_gen_load(); run(70);
    chk("R6 lock prbs7", in_sync, 1);
    pat_sel = 3'd1; do_gen_load(); run(80);
    chk("R6 lock prbs11", in_sync, 1);
    pat_sel = 3'd2; do_gen_load(); run(90);
    chk("R6 lock prbs15", in_sync, 1);

    // R2 repeating patterns of length 20 and 32
    sb_req = "R2"; pat_sel = 3'd3; rep_len = 4'd3; rep_word = 32'h000A_5F3C;
    do_gen_load(); run(80);
    chk("R6 lock repeat", in_sync, 1);
    rep_len = 4'd15; rep_word = 32'hC3A5_961E; do_gen_load(); run(70);

    // R3 transmit inversion
    sb_req = "R3"; pat_sel = 3'd0; tx_inv = 1'b1; do_gen_load(); run(30); tx_inv = 1'b0;

    // R4 single inserted error
    sb_req = "R4"; do_gen_load(); run(5); do_single(); run(8);

    // R5 automatic error rates 1e-1 and 1e-2
    sb_req = "R5"; err_rate = 3'd1; do_gen_load(); run(35);
    err_rate = 3'd2; do_gen_load(); run(210);
    err_rate = 3'd0;

    // R8/R9 counting while locked
    sb_req = "R1"; do_gen_load(); run(80);
    chk("R8 locked before count", in_sync, 1);
    do_loss_clr();
    chk("R7 flag cleared", loss_flag, 0);
    do_load_cnt();
    for (int i = 0; i < 50; i++) drive_bit(i == 10 || i == 30);
    do_load_cnt();
    chk("R8 bit count", bit_hold, 50);
    chk("R8 error count", err_hold, 2);
    chk("R9 counts intact sync", in_sync, 1);
    do_load_cnt();
    chk("R9 cleared by load bits", bit_hold, 0);
    chk("R9 cleared by load errs", err_hold, 0);

    // R7 loss of sync and reacquisition
    for (int i = 0; i < 12; i++) drive_bit(1'b1);
    chk("R7 sync lost", in_sync, 0);
    chk("R7 loss latched", loss_flag, 1);
    run(80);
    chk("R7 reacquired", in_sync, 1);
    chk("R7 flag still set", loss_flag, 1);
    do_loss_clr();
    chk("R7 flag clear pulse", loss_flag, 0);

    // R11 resync
    do_resync();
    chk("R11 resync drops sync", in_sync, 0);
    run(80);
    chk("R11 relock", in_sync, 1);

    // R10 overflow on a 4-bit error counter, 24-bit one unaffected
    do_load_cnt();
    for (int i = 0; i < 272; i++) drive_bit((i % 16) == 8);
    chk("R10 narrow overflow set", n_err_ovf, 1);
    chk("R10 wide no overflow", err_ovf, 0);
    do_load_cnt();
    chk("R8 wide error count", err_hold, 17);
    chk("R8 wide bit count", bit_hold, 272);
    chk("R10 narrow wrapped count", n_err_hold, 1);
    chk("R10 overflow cleared by load", n_err_ovf, 0);

    // R8 nothing counted out of sync (receive inversion mismatch)
    rx_inv = 1'b1; do_resync(); do_load_cnt(); run(100); do_load_cnt();
    chk("R8 no bits out of sync", bit_hold, 0);
    chk("R8 no errors out of sync", err_hold, 0);
    chk("R6 inverted mismatch no lock", in_sync, 0);

    // R6 matching inversion on both sides locks
    tx_inv = 1'b1; run(80);
    chk("R6 lock with both inverted", in_sync, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule